// File: doc/BRIEF.md
# Double-Buffered SPI Master Transmitter

This block is a byte-wide SPI master whose transmit side has a one-entry holding register in front of the shift register. Host logic writes a byte into the holding register. The engine copies it into the shift register as soon as the shifter is free. While that byte shifts out, the host may queue the next one. The queued byte then follows the previous byte with no idle serial-clock time between them.

Every transfer is full duplex. The bits arriving on MISO collect in the same shift register. When the last bit is in, the assembled byte is copied to a receive data register and a receive-full flag is raised. The host clears that flag in two steps: first a status read made while the flag is set, then a data read. The serial clock is derived from the bus clock by a fixed even divisor. The clock mode is fixed: phase 1, polarity 0, most significant bit first.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, busy is 0, sclk is 0, mosi is 0 and rx_data is 0.
- R2: A write (wr_en high for one cycle) while tx_empty is 1 is accepted. tx_empty reads 0 after that clock edge. While the byte stays queued behind an active transfer, tx_empty remains 0.
- R3: With the engine idle, an accepted write is moved into the shift register on the next clock edge. tx_empty returns to 1 and busy rises on that same edge, which is the second edge counting the write edge.
- R4: sclk is low whenever busy is 0. While busy, every high phase and every low phase of sclk lasts exactly CLK_DIV/2 bus cycles. Each byte takes 8 sclk periods. mosi changes only on rising sclk edges and carries the byte most significant bit first. miso is sampled on falling sclk edges.
- R5: If a byte is queued when the last falling edge of a transfer occurs, it is loaded on that edge and tx_empty becomes 1 there. Its first rising edge follows CLK_DIV/2 bus cycles later, the same spacing as between bits.
- R6: On the clock edge of the last falling sclk edge of a byte, the received byte (first miso bit as the most significant bit) appears on rx_data and rx_full becomes 1.
- R7: rx_full clears only on a data read (data_rd) that follows a status read (stat_rd) made while rx_full was 1. A data read without such a status read leaves rx_full at 1. A transfer completing after the status read cancels it, so a new status read is needed.
- R8: busy stays high from the load of a byte until the last falling sclk edge of a byte with nothing queued. It does not drop between queued bytes.
- R9: A write while tx_empty is 0 is ignored. The queued byte is unchanged and the written byte is never transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Transmit data write strobe |
| wr_data | input | DATA_W | Byte to queue for transmission |
| stat_rd | input | 1 | Status read strobe (first step of the receive-full clear) |
| data_rd | input | 1 | Receive data read strobe |
| rx_data | output | DATA_W | Receive data register |
| tx_empty | output | 1 | Holding register can accept a byte |
| rx_full | output | 1 | Receive data register holds an unread byte |
| busy | output | 1 | A byte is shifting |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with DATA_W = 8 and CLK_DIV = 4. This gives a half period of two bus cycles, so a stretched or shortened phase of sclk is visible as a run length other than 2. Byte-wide data lets the bench sweep every one of the 256 transmit values through a single transfer, while a slave model returns a computed pattern on miso. Short bursts exercise queueing at the end of a byte, the rejected third write and the cancellation of a pending receive-full clear.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  typedef enum logic {
    SCK_LOW  = 1'b0,
    SCK_HIGH = 1'b1
  } sck_level_t;

  // Bus cycles per serial-clock phase
  function automatic int half_of(input int div);
    return div / 2;
  endfunction

  // Bits needed to count phases (at least one bit)
  function automatic int phase_cnt_bits(input int div);
    return (div / 2 > 1) ? $clog2(div / 2) : 1;
  endfunction

endpackage

// File: rtl/spi_dbuf_clkgen.sv
module spi_dbuf_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_tick
);
  import spi_dbuf_pkg::*;

  localparam int HALF  = half_of(CLK_DIV);
  localparam int CNT_W = phase_cnt_bits(CLK_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign phase_tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || phase_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  initial begin
    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0)
      $error("CLK_DIV must be an even value of at least 2");
  end
endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_tick,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              miso,
  output logic              hold_take,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              active,
  output logic              sclk,
  output logic              mosi
);
  import spi_dbuf_pkg::*;

  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] sr,
                                                 input logic in_bit);
    return {sr[DATA_W-2:0], in_bit};
  endfunction

  logic [DATA_W-1:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              active_q;
  sck_level_t        sck_q;
  logic              mosi_q;
  logic              rise_ev;
  logic              fall_ev;

  assign rise_ev   = active_q && phase_tick && (sck_q == SCK_LOW);
  assign fall_ev   = active_q && phase_tick && (sck_q == SCK_HIGH);
  assign xfer_done = fall_ev && (bit_q == LAST_BIT);
  assign hold_take = hold_valid && (!active_q || xfer_done);
  assign rx_byte   = shift_in(sr_q, miso);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= SCK_LOW;
      mosi_q   <= 1'b0;
    end else if (!active_q) begin
      if (hold_valid) begin
        sr_q     <= hold_data;
        bit_q    <= '0;
        active_q <= 1'b1;
      end
    end else if (rise_ev) begin
      sck_q  <= SCK_HIGH;
      mosi_q <= sr_q[DATA_W-1];
    end else if (fall_ev) begin
      sck_q <= SCK_LOW;
      if (xfer_done) begin
        bit_q <= '0;
        if (hold_valid) begin
          sr_q <= hold_data;
        end else begin
          sr_q     <= rx_byte;
          active_q <= 1'b0;
        end
      end else begin
        sr_q  <= rx_byte;
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign sclk   = (sck_q == SCK_HIGH);
  assign mosi   = mosi_q;
endmodule

// File: rtl/spi_dbuf_hostregs.sv
module spi_dbuf_hostregs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              hold_take,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic [DATA_W-1:0] rx_data
);
  logic              hold_v_q;
  logic [DATA_W-1:0] hold_d_q;
  logic              full_q;
  logic              armed_q;
  logic [DATA_W-1:0] rx_q;
  logic              wr_accept;
  logic              clr_fire;

  assign wr_accept = wr_en && !hold_v_q;
  assign clr_fire  = data_rd && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (wr_accept) begin
      hold_v_q <= 1'b1;
      hold_d_q <= wr_data;
    end else if (hold_take) begin
      hold_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_q    <= '0;
    end else if (xfer_done) begin
      full_q  <= 1'b1;
      armed_q <= 1'b0;
      rx_q    <= rx_byte;
    end else if (clr_fire) begin
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd && full_q) begin
      armed_q <= 1'b1;
    end
  end

  assign hold_valid = hold_v_q;
  assign hold_data  = hold_d_q;
  assign tx_empty   = !hold_v_q;
  assign rx_full    = full_q;
  assign rx_data    = rx_q;
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              phase_tick;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              hold_take;
  logic              xfer_done;
  logic [DATA_W-1:0] rx_byte;
  logic              active;

  spi_dbuf_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (active),
    .phase_tick (phase_tick)
  );

  spi_dbuf_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_tick (phase_tick),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .miso       (miso),
    .hold_take  (hold_take),
    .xfer_done  (xfer_done),
    .rx_byte    (rx_byte),
    .active     (active),
    .sclk       (sclk),
    .mosi       (mosi)
  );

  spi_dbuf_hostregs #(.DATA_W(DATA_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .hold_take  (hold_take),
    .xfer_done  (xfer_done),
    .rx_byte    (rx_byte),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_data    (rx_data)
  );

  assign busy = active;
endmodule

// File: rtl/spi_dbuf_checker.sv
module spi_dbuf_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic data_rd,
  input logic tx_empty,
  input logic rx_full,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic hold_take,
  input logic xfer_done
);
  assert_wr_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_empty) |=> !tx_empty);

  assert_queued_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !hold_take) |=> !tx_empty);

  assert_idle_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !busy) |=> (tx_empty && busy));

  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk) |-> $stable(mosi));

  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && hold_take) |=> (busy && !sclk && tx_empty));

  assert_done_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> rx_full);

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !data_rd) |=> rx_full);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(xfer_done));
endmodule

bind spi_dbuf_master spi_dbuf_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .data_rd   (data_rd),
  .tx_empty  (tx_empty),
  .rx_full   (rx_full),
  .busy      (busy),
  .sclk      (sclk),
  .mosi      (mosi),
  .hold_take (hold_take),
  .xfer_done (xfer_done)
);

// File: tb/spi_dbuf_master_tb.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb_top;
  localparam int W    = 8;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         stat_rd = 1'b0;
  logic         data_rd = 1'b0;
  logic [W-1:0] rx_data;
  logic         tx_empty, rx_full, busy, sclk, mosi;
  logic         miso = 1'b0;

  int n_total = 0;
  int n_pass  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_dbuf_master #(.DATA_W(W), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [W-1:0] slv_pat(input int idx);
    return W'((idx * 53 + 29) ^ (idx >> 3));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  // Slave model: drives miso on rising sclk, captures mosi on falling sclk
  logic [W-1:0] slv_log [0:1023];
  logic [W-1:0] slv_sh = '0;
  int           slv_bit = 0;
  int           slv_idx = 0;

  always @(posedge sclk) begin
    logic [W-1:0] p;
    p = slv_pat(slv_idx);
    miso <= p[W-1-slv_bit];
  end

  always @(negedge sclk) begin
    slv_sh = {slv_sh[W-2:0], mosi};
    slv_bit++;
    if (slv_bit == W) begin
      slv_log[slv_idx] = slv_sh;
      slv_idx++;
      slv_bit = 0;
    end
  end

  // Waveform monitor for phase lengths, mosi changes and busy drops
  int   phase_viol = 0;
  int   mosi_viol  = 0;
  int   rises      = 0;
  int   busy_falls = 0;
  int   run_len    = 0;
  logic sclk_p = 1'b0, mosi_p = 1'b0, busy_p = 1'b0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (busy_p) begin
        if (sclk != sclk_p) begin
          if (run_len != HALF) phase_viol++;
          run_len = 1;
        end else begin
          run_len++;
        end
      end else begin
        run_len = 1;
      end
      if (!busy && sclk) phase_viol++;
      if (sclk && !sclk_p) rises++;
      if (mosi != mosi_p && !(sclk && !sclk_p)) mosi_viol++;
      if (busy_p && !busy) busy_falls++;
    end
    sclk_p = sclk;
    mosi_p = mosi;
    busy_p = busy;
  end

  task automatic pulse_wr(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  // Write to an idle engine with edge-exact flag checks
  task automatic idle_write(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    check(!tx_empty && !busy, "R2 empty clears on write", tx_empty, 0);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check(tx_empty && busy, "R3 refill on second edge", {tx_empty, busy}, 3);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(posedge clk); #1;
      guard++;
    end
  endtask

  task automatic wait_empty();
    int guard = 0;
    while (!tx_empty && guard < 1000) begin
      @(posedge clk); #1;
      guard++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    int sent;
    int falls_before;
    logic [W-1:0] bv [0:2];
    sent = 0;

    repeat (3) @(posedge clk);
    #1;
    check(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);
    check(rx_full == 1'b0, "R1 reset rx_full", rx_full, 0);
    check(busy == 1'b0 && sclk == 1'b0, "R1 reset busy/sclk", {busy, sclk}, 0);
    check(mosi == 1'b0 && rx_data == '0, "R1 reset mosi/rx_data", {mosi, rx_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(tx_empty && !rx_full && !busy && !sclk, "R1 after release",
          {tx_empty, rx_full, busy, sclk}, 8);

    // Single-byte sweep over every transmit value
    for (int v = 0; v < 256; v++) begin
      idle_write(W'(v));
      wait_idle();
      sent++;
      check(slv_idx == sent && slv_log[sent-1] == W'(v), "R4 mosi byte msb first",
            slv_log[sent-1], v);
      check(rx_full == 1'b1, "R6 rx_full set at end", rx_full, 1);
      check(rx_data == slv_pat(sent-1), "R6 rx_data from miso", rx_data, slv_pat(sent-1));
      pulse_data();
      #1;
      check(rx_full == 1'b1, "R7 data read alone keeps full", rx_full, 1);
      pulse_stat();
      pulse_data();
      #1;
      check(rx_full == 1'b0, "R7 status then data clears", rx_full, 0);
    end

    // Bursts: queued byte, ignored write, then refill at end of byte
    for (int b = 0; b < 4; b++) begin
      bv[0] = W'(8'hA5 + b * 17);
      bv[1] = W'(8'h3C ^ (b * 29));
      bv[2] = W'(8'hF0 - b * 7);
      falls_before = busy_falls;
      idle_write(bv[0]);
      pulse_wr(bv[1]);
      #1;
      check(tx_empty == 1'b0, "R2 queued byte holds empty low", tx_empty, 0);
      pulse_wr(W'(~bv[1]));
      wait_empty();
      check(busy == 1'b1, "R8 busy high at handover", busy, 1);
      check(slv_idx == sent + 1, "R5 handover at end of first byte", slv_idx, sent + 1);
      pulse_wr(bv[2]);
      wait_idle();
      check(busy_falls == falls_before + 1, "R8 single busy drop per burst",
            busy_falls - falls_before, 1);
      check(slv_idx == sent + 3, "R9 ignored write not sent", slv_idx, sent + 3);
      for (int k = 0; k < 3; k++)
        check(slv_log[sent+k] == bv[k], "R9 burst byte order", slv_log[sent+k], bv[k]);
      sent += 3;
      check(rx_data == slv_pat(sent-1), "R6 rx_data after burst", rx_data, slv_pat(sent-1));
      pulse_stat();
      pulse_data();
    end

    // Status read cancelled by a new completion
    idle_write(8'h5A);
    wait_idle();
    sent++;
    pulse_stat();
    idle_write(8'hC3);
    wait_idle();
    sent++;
    pulse_data();
    #1;
    check(rx_full == 1'b1, "R7 completion cancels status read", rx_full, 1);
    pulse_stat();
    pulse_data();
    #1;
    check(rx_full == 1'b0, "R7 fresh status read clears", rx_full, 0);

    repeat (4) @(posedge clk);
    #1;
    check(phase_viol == 0, "R4 phase lengths and idle level", phase_viol, 0);
    check(mosi_viol == 0, "R4 mosi changes on rise only", mosi_viol, 0);
    check(rises == W * sent, "R4 eight periods per byte", rises, W * sent);
    check(phase_viol == 0 && slv_idx == sent, "R5 no gap between queued bytes",
          slv_idx, sent);

    finished = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule